// File: doc/BRIEF.md
# Phase-Angle Islanding Trip Unit

This block decides whether a generator has become electrically separated from the main grid. It compares two synchronised positive-sequence voltage angles: one measured at the local bus and one sent from a remote bus. When the two sites drift apart by more than a settable angle, and they stay apart for a settable number of power-frequency cycles, the block issues a trip.

Each new pair of angles comes with a frame-valid strobe. Measurement frames nominally arrive 50 times per second. On a strobe, the block takes the signed difference between the two angles. It folds that difference into the half-open range of minus to plus 180 degrees, takes the magnitude, and compares the magnitude with the threshold register. The comparator result is held until the next strobe.

A pickup counter advances on each power-cycle tick while the comparator is high. When the count reaches the configured pickup value, the timer output rises, and on the following clock edge a sticky trip flag is set. Only reset clears the trip flag.

Angles and the threshold are fixed point with `FRAC_W` fractional bits. With the default of 6, one degree is 64 LSB. The threshold register resets to 8 degrees (512 LSB).

Top module: `iti_trip_unit`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: `cmp_o`=0, `tmr_cnt_o`=0, `tmr_state_o`=0 (idle), `tmr_pick_o`=0 and `trip_o`=0. The threshold register holds 8 degrees (512 LSB).
- R2: `cmp_o` is recomputed only at a clock edge where `frame_vld_i`=1. Angle changes without a strobe leave `cmp_o` unchanged.
- R3: `cmp_o` becomes 1 only when the folded magnitude is strictly greater than the threshold. A magnitude equal to the threshold gives 0, whatever the sign of the difference.
- R4: The difference local minus remote is folded by adding or subtracting 360 degrees, so that it lies between -180 and +180. Example: local 178, remote -178 gives a magnitude of 4 degrees. Example: local 175, remote -176 gives 9 degrees.
- R5: A clock edge with `thr_we_i`=1 loads `thr_i` into the threshold register. A comparison strobed in that same cycle still uses the previous threshold.
- R6: While `cmp_o`=1, each `cyc_tick_i` edge raises `tmr_cnt_o` by one, up to `pickup_i` and no further. Edges without a tick leave the count unchanged. Ticks while `cmp_o`=0 leave the count at 0.
- R7: When `cmp_o` is 0, `tmr_state_o` reads idle (0). On the next edge, `tmr_cnt_o` clears to 0. A later pickup counts from zero again.
- R8: `tmr_state_o` reads 1 (timing) while `cmp_o`=1 and the count is below `pickup_i`. It reads 2 (picked up, with `tmr_pick_o`=1) once the count reaches `pickup_i`. `trip_o` rises on the clock edge after `tmr_pick_o` first reads 1.
- R9: Once `trip_o` is 1, it stays 1 until reset, even after the comparator and the timer drop.
- R10: With `pickup_i`=0, the timer is picked up in the same cycle that `cmp_o` rises.
- R11: Suppose one edge both drops the comparator (a strobe with a small difference) and carries the tick that would complete the pickup. Then no trip results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld_i | input | 1 | Strobe: new angle pair is valid |
| loc_ang_i | input | ANG_W | Local angle, signed fixed-point degrees |
| rem_ang_i | input | ANG_W | Remote angle, signed fixed-point degrees |
| thr_we_i | input | 1 | Load enable for the threshold register |
| thr_i | input | ANG_W | New threshold, unsigned fixed-point degrees |
| cyc_tick_i | input | 1 | One pulse per power-frequency cycle |
| pickup_i | input | CNT_W | Pickup length in power cycles |
| cmp_o | output | 1 | Held comparator result |
| tmr_state_o | output | 2 | Timer state: 0 idle, 1 timing, 2 picked up |
| tmr_cnt_o | output | CNT_W | Pickup counter value |
| tmr_pick_o | output | 1 | Timer output (pickup reached) |
| trip_o | output | 1 | Latched trip |

## Verification
The comparator update and the pickup tick can land on the same clock edge. In one case the strobe carries a small angle difference that drops the comparator, while the tick would bring the counter to its pickup value. The bench drives exactly that edge after counting up to one short of pickup. It then checks that the timer reads idle, that the trip never sets, and that the counter has cleared one cycle later. A second coincidence, a threshold write on the same edge as a strobe, is judged by expecting the old threshold to decide that frame's result.

// File: rtl/iti_pkg.sv
package iti_pkg;

    // Timer state as seen at the ports
    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_TIMING = 2'd1,
        TMR_PICKED = 2'd2
    } tmr_state_e;

    // Bundle of the decision flags carried between stages
    typedef struct packed {
        logic above;   // held comparator result
        logic picked;  // timer output
        logic trip;    // latched trip
    } iti_flags_t;

    localparam int HALF_TURN_DEG = 180;
    localparam int FULL_TURN_DEG = 360;

    // Scale whole degrees into fixed point
    function automatic int deg_to_fix(input int deg, input int frac_w);
        return deg * (2 ** frac_w);
    endfunction

endpackage

// File: rtl/iti_angle_cmp.sv
module iti_angle_cmp
    import iti_pkg::*;
#(
    parameter int ANG_W       = 16,
    parameter int FRAC_W      = 6,
    parameter int DEF_THR_DEG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_vld_i,
    input  logic signed [ANG_W-1:0] loc_i,
    input  logic signed [ANG_W-1:0] rem_i,
    input  logic                    thr_we_i,
    input  logic        [ANG_W-1:0] thr_i,
    output logic                    cmp_o
);
    localparam int DW     = ANG_W + 2;
    localparam int HALF_I = deg_to_fix(HALF_TURN_DEG, FRAC_W);
    localparam int FULL_I = deg_to_fix(FULL_TURN_DEG, FRAC_W);
    localparam int DEF_I  = deg_to_fix(DEF_THR_DEG, FRAC_W);
    localparam logic signed [DW-1:0]  HALF    = HALF_I[DW-1:0];
    localparam logic signed [DW-1:0]  FULL    = FULL_I[DW-1:0];
    localparam logic [ANG_W-1:0]      DEF_THR = DEF_I[ANG_W-1:0];

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] folded;
    logic signed [DW-1:0] mag;
    logic signed [DW-1:0] thr_ext;
    logic                 above;
    logic [ANG_W-1:0]     thr_q;
    logic                 cmp_q;

    // Signed difference, folded into one turn centred on zero
    always_comb begin
        diff = DW'(loc_i) - DW'(rem_i);
        if (diff > HALF)
            folded = diff - FULL;
        else if (diff < -HALF)
            folded = diff + FULL;
        else
            folded = diff;
        mag     = (folded < 0) ? -folded : folded;
        thr_ext = $signed({2'b00, thr_q});
        above   = (mag > thr_ext);
    end

    // Settable threshold
    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= DEF_THR;
        else if (thr_we_i)
            thr_q <= thr_i;
    end

    // Comparator result held between strobes
    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= 1'b0;
        else if (frame_vld_i)
            cmp_q <= above;
    end

    assign cmp_o = cmp_q;

    // R2: no strobe, no change of the held result
    p_cmp_hold_r2 : assert property (@(posedge clk) disable iff (rst)
        !frame_vld_i |=> $stable(cmp_q));

    // R5: a load takes effect on the following edge
    p_thr_load_r5 : assert property (@(posedge clk) disable iff (rst)
        thr_we_i |=> (thr_q == $past(thr_i)));

endmodule

// File: rtl/iti_pickup_timer.sv
module iti_pickup_timer
    import iti_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] pickup_i,
    output logic [CNT_W-1:0] cnt_o,
    output tmr_state_e       state_o,
    output logic             picked_o
);
    logic [CNT_W-1:0] cnt_q;
    tmr_state_e       state;

    // Counts power cycles while the condition holds; clears when it drops
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!cmp_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q < pickup_i))
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        if (!cmp_i)
            state = TMR_IDLE;
        else if (cnt_q >= pickup_i)
            state = TMR_PICKED;
        else
            state = TMR_TIMING;
    end

    assign cnt_o    = cnt_q;
    assign state_o  = state;
    assign picked_o = (state == TMR_PICKED);

    // R7: a dropped condition leaves a cleared counter behind
    p_clear_r7 : assert property (@(posedge clk) disable iff (rst)
        !cmp_i |=> (cnt_q == '0));

    // R6: without a tick the count does not move
    p_no_tick_r6 : assert property (@(posedge clk) disable iff (rst)
        (cmp_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/iti_trip_latch.sv
module iti_trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic picked_i,
    output logic trip_o
);
    logic trip_q;

    always_ff @(posedge clk) begin
        if (rst)
            trip_q <= 1'b0;
        else if (picked_i)
            trip_q <= 1'b1;
    end

    assign trip_o = trip_q;

    // R9: sticky until reset
    p_trip_sticky_r9 : assert property (@(posedge clk) disable iff (rst)
        trip_q |=> trip_q);

    // R8: a rising trip is always caused by the timer one edge earlier
    p_trip_cause_r8 : assert property (@(posedge clk) disable iff (rst)
        $rose(trip_q) |-> $past(picked_i));

endmodule

// File: rtl/iti_trip_unit.sv
module iti_trip_unit
    import iti_pkg::*;
#(
    parameter int ANG_W       = 16,
    parameter int FRAC_W      = 6,
    parameter int DEF_THR_DEG = 8,
    parameter int CNT_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_vld_i,
    input  logic signed [ANG_W-1:0] loc_ang_i,
    input  logic signed [ANG_W-1:0] rem_ang_i,
    input  logic                    thr_we_i,
    input  logic        [ANG_W-1:0] thr_i,
    input  logic                    cyc_tick_i,
    input  logic        [CNT_W-1:0] pickup_i,
    output logic                    cmp_o,
    output logic        [1:0]       tmr_state_o,
    output logic        [CNT_W-1:0] tmr_cnt_o,
    output logic                    tmr_pick_o,
    output logic                    trip_o
);
    iti_flags_t flags;
    tmr_state_e tmr_state;

    iti_angle_cmp #(
        .ANG_W      (ANG_W),
        .FRAC_W     (FRAC_W),
        .DEF_THR_DEG(DEF_THR_DEG)
    ) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .frame_vld_i(frame_vld_i),
        .loc_i      (loc_ang_i),
        .rem_i      (rem_ang_i),
        .thr_we_i   (thr_we_i),
        .thr_i      (thr_i),
        .cmp_o      (flags.above)
    );

    iti_pickup_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .cmp_i   (flags.above),
        .tick_i  (cyc_tick_i),
        .pickup_i(pickup_i),
        .cnt_o   (tmr_cnt_o),
        .state_o (tmr_state),
        .picked_o(flags.picked)
    );

    iti_trip_latch u_trip (
        .clk     (clk),
        .rst     (rst),
        .picked_i(flags.picked),
        .trip_o  (flags.trip)
    );

    assign cmp_o       = flags.above;
    assign tmr_pick_o  = flags.picked;
    assign trip_o      = flags.trip;
    assign tmr_state_o = tmr_state;

    // R11: the timer can never report picked up while the comparator is low
    p_pick_needs_cmp_r11 : assert property (@(posedge clk) disable iff (rst)
        !flags.above |-> !flags.picked);

endmodule

// File: tb/iti_trip_unit_tb_top.sv
module iti_trip_unit_tb_top;
    localparam int ANG_W = 16;
    localparam int CNT_W = 8;
    localparam int ONE   = 64;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    frame_vld_i = 1'b0;
    logic signed [ANG_W-1:0] loc_ang_i = '0;
    logic signed [ANG_W-1:0] rem_ang_i = '0;
    logic                    thr_we_i = 1'b0;
    logic        [ANG_W-1:0] thr_i = '0;
    logic                    cyc_tick_i = 1'b0;
    logic        [CNT_W-1:0] pickup_i = 8'd10;
    logic                    cmp_o;
    logic        [1:0]       tmr_state_o;
    logic        [CNT_W-1:0] tmr_cnt_o;
    logic                    tmr_pick_o;
    logic                    trip_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    iti_trip_unit dut_i (
        .clk(clk), .rst(rst), .frame_vld_i(frame_vld_i),
        .loc_ang_i(loc_ang_i), .rem_ang_i(rem_ang_i),
        .thr_we_i(thr_we_i), .thr_i(thr_i), .cyc_tick_i(cyc_tick_i),
        .pickup_i(pickup_i), .cmp_o(cmp_o), .tmr_state_o(tmr_state_o),
        .tmr_cnt_o(tmr_cnt_o), .tmr_pick_o(tmr_pick_o), .trip_o(trip_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int deg(input int d);
        return d * ONE;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_vld_i = 1'b0; cyc_tick_i = 1'b0; thr_we_i = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    // One strobed frame, optionally with a tick and a threshold load on the same edge
    task automatic frame(input int l, input int r, input bit tk = 1'b0,
                         input bit we = 1'b0, input int thr = 0);
        loc_ang_i   = 16'(l);
        rem_ang_i   = 16'(r);
        frame_vld_i = 1'b1;
        cyc_tick_i  = tk;
        thr_we_i    = we;
        thr_i       = 16'(thr);
        @(negedge clk);
        frame_vld_i = 1'b0; cyc_tick_i = 1'b0; thr_we_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick_i = 1'b1;
            @(negedge clk);
            cyc_tick_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cmp", cmp_o, 0);
        chk("R1 cnt", tmr_cnt_o, 0);
        chk("R1 state", tmr_state_o, 0);
        chk("R1 pick", tmr_pick_o, 0);
        chk("R1 trip", trip_o, 0);
    endtask

    task automatic t_strict();
        do_reset();
        frame(deg(10), deg(2));
        chk("R1/R3 equal to default threshold", cmp_o, 0);
        frame(deg(10) + 1, deg(2));
        chk("R1/R3 one LSB above default", cmp_o, 1);
        frame(deg(2), deg(10));
        chk("R3 negative equal", cmp_o, 0);
        frame(deg(2), deg(10) + 1);
        chk("R3 negative above", cmp_o, 1);
    endtask

    task automatic t_hold();
        do_reset();
        frame(deg(20), deg(0));
        chk("R2 set", cmp_o, 1);
        loc_ang_i = 16'(deg(3)); rem_ang_i = 16'(deg(3));
        idle(3);
        chk("R2 held without strobe", cmp_o, 1);
        frame(deg(3), deg(3));
        chk("R2 updated on strobe", cmp_o, 0);
        loc_ang_i = 16'(deg(90)); rem_ang_i = 16'(deg(-10));
        idle(3);
        chk("R2 held low without strobe", cmp_o, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        frame(deg(178), deg(-178));
        chk("R4 wrap to 4 deg", cmp_o, 0);
        frame(deg(175), deg(-176));
        chk("R4 wrap to 9 deg", cmp_o, 1);
        frame(deg(-178), deg(178));
        chk("R4 negative wrap to 4 deg", cmp_o, 0);
        frame(deg(-175), deg(176));
        chk("R4 negative wrap to 9 deg", cmp_o, 1);
        frame(deg(90), deg(-90));
        chk("R4 half turn", cmp_o, 1);
    endtask

    task automatic t_thr();
        do_reset();
        frame(deg(10), deg(0), 1'b0, 1'b1, deg(20));
        chk("R5 same-edge uses old threshold", cmp_o, 1);
        frame(deg(10), deg(0));
        chk("R5 new threshold applies", cmp_o, 0);
        frame(deg(20), deg(0));
        chk("R5 equal to new threshold", cmp_o, 0);
        frame(deg(21), deg(0));
        chk("R5 above new threshold", cmp_o, 1);
    endtask

    task automatic t_timer();
        do_reset();
        pickup_i = 8'd10;
        ticks(3);
        chk("R6 ticks ignored while low", tmr_cnt_o, 0);
        frame(deg(20), deg(0));
        chk("R8 timing state", tmr_state_o, 1);
        chk("R6 start count", tmr_cnt_o, 0);
        ticks(9);
        chk("R6 count 9", tmr_cnt_o, 9);
        idle(2);
        chk("R6 stable without tick", tmr_cnt_o, 9);
        chk("R8 not yet picked", tmr_pick_o, 0);
        ticks(1);
        chk("R8 picked state", tmr_state_o, 2);
        chk("R8 pick output", tmr_pick_o, 1);
        chk("R8 trip one edge later", trip_o, 0);
        idle(1);
        chk("R8 trip set", trip_o, 1);
        ticks(4);
        chk("R6 saturates at pickup", tmr_cnt_o, 10);
    endtask

    task automatic t_clear();
        do_reset();
        pickup_i = 8'd10;
        frame(deg(20), deg(0));
        ticks(5);
        chk("R6 count 5", tmr_cnt_o, 5);
        frame(deg(0), deg(0));
        chk("R7 idle on drop", tmr_state_o, 0);
        idle(1);
        chk("R7 counter cleared", tmr_cnt_o, 0);
        frame(deg(20), deg(0));
        ticks(9);
        chk("R7 restart from zero", tmr_cnt_o, 9);
        chk("R7 no trip", trip_o, 0);
    endtask

    task automatic t_latch();
        do_reset();
        pickup_i = 8'd2;
        frame(deg(30), deg(0));
        ticks(2);
        idle(1);
        chk("R9 tripped", trip_o, 1);
        frame(deg(0), deg(0));
        idle(4);
        chk("R9 comparator low", cmp_o, 0);
        chk("R9 trip held", trip_o, 1);
        do_reset();
        chk("R9 cleared by reset", trip_o, 0);
    endtask

    task automatic t_zero();
        do_reset();
        pickup_i = 8'd0;
        frame(deg(20), deg(0));
        chk("R10 picked at once", tmr_state_o, 2);
        idle(1);
        chk("R10 trip", trip_o, 1);
    endtask

    task automatic t_coinc();
        do_reset();
        pickup_i = 8'd3;
        frame(deg(20), deg(0));
        ticks(2);
        chk("R11 count 2", tmr_cnt_o, 2);
        frame(deg(1), deg(0), 1'b1);
        chk("R11 idle after drop", tmr_state_o, 0);
        chk("R11 no pick", tmr_pick_o, 0);
        idle(3);
        chk("R11 no trip", trip_o, 0);
        chk("R11 counter cleared", tmr_cnt_o, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_strict();
        t_hold();
        t_wrap();
        t_thr();
        t_timer();
        t_clear();
        t_latch();
        t_zero();
        t_coinc();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule